// File: doc/BRIEF.md
# CAN Fault-Confinement Status and Interrupt Unit

This block follows the fault-confinement state of a CAN controller and raises one status interrupt line. The protocol engine sends it single-cycle strobes: transmit error, receive error, successful transmit, successful receive, a last-error-code update, and a request to recover from bus-off. From these strobes the block keeps a transmit error counter and a receive error counter. It derives a warning flag, an error-passive flag and a bus-off flag from the counters.

The CPU reads two words. The status word carries the three fault flags and a writable low field: receive-OK, transmit-OK and the last error code. The counter word packs both counters and a receive-passive flag. The interrupt has two enables. The error enable covers changes of the warning and bus-off flags. The status enable covers engine updates of the low field. Reading the status word clears a pending interrupt.

Top module: `can_fault_irq`

## Requirements
- R1: After reset, the status word, the counter word and `irq` are all zero.
- R2: Counter updates take effect on the clock edge that samples the strobe.
  - A transmit error adds 8 to the transmit counter. A receive error adds 1 to the receive counter.
  - A successful transmit or receive subtracts 1 from the matching counter. A counter at zero stays at zero.
  - When an error and a success hit the same counter in the same cycle, the error wins.
- R3: Status bit 6 (warning) is 1 when either counter is at 96 or more. It is 0 when both counters are below 96.
- R4: Status bit 5 (error-passive) is 1 when either counter is at 128 or more.
  - While the receive counter is at 128 or more, counter-word bits 14:8 read 127 and bit 15 reads 1.
  - Below 128, bits 14:8 read the true count and bit 15 reads 0.
- R5: Bus-off works as follows.
  - A transmit error that would take the transmit counter above 255 sets status bit 7 (bus-off) and holds the counter at 255.
  - While bus-off is set, error and success strobes leave both counters unchanged.
  - A recovery request while bus-off is set clears both counters and bus-off on the next edge.
- R6: The counter word holds the transmit counter in bits 7:0, the receive field in bits 14:8 and the receive-passive flag in bit 15. Bits 31:16 read zero, and status bits 31:8 read zero.
- R7: With `err_ie` high, a change of the warning flag or the bus-off flag sets the pending interrupt one edge after the counter update that caused the change.
- R8: The engine updates the low field of the status word: a successful receive sets bit 4, a successful transmit sets bit 3, and a valid last-error-code strobe loads bits 2:0.
  - With `stat_ie` high, any such update sets the pending interrupt on the same edge.
- R9: A change of the error-passive flag alone never raises `irq`. A CPU write loads status bits 4:0 from `cpu_wdata` and never raises `irq`.
- R10: A CPU read of the status word clears the pending interrupt. If a new interrupt event occurs in the same cycle as the read, the event wins and `irq` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_tx_err | input | 1 | Transmit error strobe |
| ev_rx_err | input | 1 | Receive error strobe |
| ev_tx_ok | input | 1 | Successful transmit strobe |
| ev_rx_ok | input | 1 | Successful receive strobe |
| ev_lec_vld | input | 1 | Last-error-code update strobe |
| ev_lec | input | 3 | Last error code value |
| recover_req | input | 1 | Bus-off recovery request |
| err_ie | input | 1 | Enable for warning and bus-off change interrupts |
| stat_ie | input | 1 | Enable for status-update interrupts |
| cpu_rd_stat | input | 1 | CPU read of the status word (clears pending) |
| cpu_wr_stat | input | 1 | CPU write of status bits 4:0 |
| cpu_wdata | input | 5 | Write data for status bits 4:0 |
| stat_word | output | 32 | Status word |
| cnt_word | output | 32 | Counter word |
| irq | output | 1 | Status interrupt line |

## Verification
The in-RTL assertions check the following on every cycle:
- the +8 transmit step;
- the floor at zero;
- the freeze of counters during bus-off;
- the recovery clear;
- that the pending flag only rises from an enabled event and drops after a read.

Only the bench's scenarios can show the rest:
- the exact counts at which warning, error-passive and bus-off appear;
- the 127 read-back once the receive counter passes 128;
- that crossing into error-passive alone leaves `irq` low;
- that a read colliding with a new event keeps `irq` high.

// File: rtl/canf_pkg.sv
// Package: shared types and bit positions for the CAN fault-confinement unit.
// Assumes a 32-bit CPU word.
package canf_pkg;
    typedef struct packed {
        logic boff;
        logic warn;
        logic pass;
    } fc_flags_t;

    localparam int WORD_W   = 32;
    localparam int LOW_W    = 5;   // rx_ok, tx_ok, lec[2:0]
    localparam int LEC_W    = 3;
    localparam int RXOK_BIT = 4;
    localparam int TXOK_BIT = 3;
endpackage

// File: rtl/canf_errcnt.sv
// Module: transmit and receive error counters with fault-confinement flags.
// Assumes single-cycle strobes from the protocol engine. The receive counter
// keeps one extra bit internally so that counts of 128 and above can be seen.
module canf_errcnt
    import canf_pkg::*;
#(
    parameter int TEC_W    = 8,
    parameter int REC_W    = 7,
    parameter int WARN_LIM = 96,
    parameter int PASS_LIM = 128,
    parameter int TX_STEP  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_err,
    input  logic             rx_err,
    input  logic             tx_ok,
    input  logic             rx_ok,
    input  logic             recover,
    output logic [TEC_W-1:0] tec,
    output logic [REC_W:0]   rec_raw,
    output fc_flags_t        flags,
    output logic             rx_pass
);
    localparam logic [TEC_W-1:0] TEC_MAX  = {TEC_W{1'b1}};
    localparam logic [TEC_W:0]   TEC_MAXW = {1'b0, TEC_MAX};
    localparam logic [REC_W:0]   REC_SAT  = {(REC_W+1){1'b1}};
    localparam logic [TEC_W-1:0] TEC_WARN = TEC_W'(WARN_LIM);
    localparam logic [TEC_W-1:0] TEC_PASS = TEC_W'(PASS_LIM);
    localparam logic [REC_W:0]   REC_WARN = (REC_W+1)'(WARN_LIM);
    localparam logic [REC_W:0]   REC_PASS = (REC_W+1)'(PASS_LIM);
    localparam logic [TEC_W-1:0] TEC_STEP = TEC_W'(TX_STEP);

    logic [TEC_W-1:0] tec_q;
    logic [REC_W:0]   rec_q;
    logic             boff_q;
    logic [TEC_W:0]   tec_sum;

    // Candidate transmit count after one error, one bit wider to catch overflow.
    always_comb tec_sum = {1'b0, tec_q} + {1'b0, TEC_STEP};

    // Counter and bus-off state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tec_q  <= '0;
            rec_q  <= '0;
            boff_q <= 1'b0;
        end else if (boff_q) begin
            if (recover) begin
                tec_q  <= '0;
                rec_q  <= '0;
                boff_q <= 1'b0;
            end
        end else begin
            if (tx_err) begin
                if (tec_sum > TEC_MAXW) begin
                    tec_q  <= TEC_MAX;
                    boff_q <= 1'b1;
                end else begin
                    tec_q <= tec_sum[TEC_W-1:0];
                end
            end else if (tx_ok && tec_q != '0) begin
                tec_q <= tec_q - 1'b1;
            end
            if (rx_err) begin
                if (rec_q != REC_SAT) rec_q <= rec_q + 1'b1;
            end else if (rx_ok && rec_q != '0) begin
                rec_q <= rec_q - 1'b1;
            end
        end
    end

    // Flag derivation from the current counts.
    always_comb begin
        flags.warn = (tec_q >= TEC_WARN) || (rec_q >= REC_WARN);
        flags.pass = (tec_q >= TEC_PASS) || (rec_q >= REC_PASS);
        flags.boff = boff_q;
        rx_pass    = (rec_q >= REC_PASS);
        tec        = tec_q;
        rec_raw    = rec_q;
    end

    // R2
    tx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!boff_q && tx_err && tec_sum <= TEC_MAXW) |=> (tec_q == $past(tec_q) + TEC_STEP));

    // R2
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tec_q == '0 && rec_q == '0 && !tx_err && !rx_err) |=> (tec_q == '0 && rec_q == '0));

    // R5
    boff_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (boff_q && !recover) |=> (boff_q && $stable(tec_q) && $stable(rec_q)));

    // R5
    recover_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (boff_q && recover) |=> (!boff_q && tec_q == '0 && rec_q == '0));
endmodule

// File: rtl/canf_stat_irq.sv
// Module: low status field (receive-OK, transmit-OK, last error code) and
// status interrupt pending logic.
// Assumes the fault flags come from registers, so a one-cycle delayed copy
// is enough to detect a change.
module canf_stat_irq
    import canf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  fc_flags_t        flags,
    input  logic             rx_ok,
    input  logic             tx_ok,
    input  logic             lec_vld,
    input  logic [LEC_W-1:0] lec,
    input  logic             err_ie,
    input  logic             stat_ie,
    input  logic             cpu_rd,
    input  logic             cpu_wr,
    input  logic [LOW_W-1:0] cpu_wdata,
    output logic [LOW_W-1:0] low_bits,
    output logic             irq
);
    logic             rxok_q, txok_q;
    logic [LEC_W-1:0] lec_q;
    logic             warn_q, boff_q, pend_q;
    logic             err_ev, st_ev;

    // Low status field: an engine update wins over a CPU write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxok_q <= 1'b0;
            txok_q <= 1'b0;
            lec_q  <= '0;
        end else begin
            if (rx_ok)       rxok_q <= 1'b1;
            else if (cpu_wr) rxok_q <= cpu_wdata[RXOK_BIT];
            if (tx_ok)       txok_q <= 1'b1;
            else if (cpu_wr) txok_q <= cpu_wdata[TXOK_BIT];
            if (lec_vld)     lec_q  <= lec;
            else if (cpu_wr) lec_q  <= cpu_wdata[LEC_W-1:0];
        end
    end

    // Delayed copies of the warning and bus-off flags for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warn_q <= 1'b0;
            boff_q <= 1'b0;
        end else begin
            warn_q <= flags.warn;
            boff_q <= flags.boff;
        end
    end

    // Interrupt events (the error-passive flag takes no part).
    always_comb begin
        err_ev = err_ie  && ((flags.warn != warn_q) || (flags.boff != boff_q));
        st_ev  = stat_ie && (rx_ok || tx_ok || lec_vld);
    end

    // Pending flag: a new event wins over a clearing read.
    always_ff @(posedge clk) begin
        if (!rst_n)                pend_q <= 1'b0;
        else if (err_ev || st_ev) pend_q <= 1'b1;
        else if (cpu_rd)          pend_q <= 1'b0;
    end

    always_comb begin
        low_bits = {rxok_q, txok_q, lec_q};
        irq      = pend_q;
    end

    // R7
    err_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_ie && flags.warn != warn_q) |=> pend_q);

    // R8
    stat_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_ie && rx_ok) |=> (pend_q && rxok_q));

    // R9
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q) |-> $past(err_ev || st_ev));

    // R10
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !err_ev && !st_ev) |=> !pend_q);
endmodule

// File: rtl/can_fault_irq.sv
// Module: top of the CAN fault-confinement status and interrupt unit.
// It assembles the CPU-visible status and counter words.
// Assumes the counter widths plus the passive flag fit in 32 bits.
module can_fault_irq
    import canf_pkg::*;
#(
    parameter int TEC_W    = 8,
    parameter int REC_W    = 7,
    parameter int WARN_LIM = 96,
    parameter int PASS_LIM = 128,
    parameter int TX_STEP  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_tx_err,
    input  logic              ev_rx_err,
    input  logic              ev_tx_ok,
    input  logic              ev_rx_ok,
    input  logic              ev_lec_vld,
    input  logic [2:0]        ev_lec,
    input  logic              recover_req,
    input  logic              err_ie,
    input  logic              stat_ie,
    input  logic              cpu_rd_stat,
    input  logic              cpu_wr_stat,
    input  logic [4:0]        cpu_wdata,
    output logic [31:0]       stat_word,
    output logic [31:0]       cnt_word
    ,output logic             irq
);
    localparam int CNT_PAD  = WORD_W - TEC_W - REC_W - 1;
    localparam int STAT_PAD = WORD_W - LOW_W - 3;

    logic [TEC_W-1:0] tec;
    logic [REC_W:0]   rec_raw;
    logic [REC_W-1:0] rec_field;
    logic             rx_pass;
    fc_flags_t        flags;
    logic [LOW_W-1:0] low_bits;

    canf_errcnt #(
        .TEC_W(TEC_W), .REC_W(REC_W), .WARN_LIM(WARN_LIM),
        .PASS_LIM(PASS_LIM), .TX_STEP(TX_STEP)
    ) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .tx_err(ev_tx_err), .rx_err(ev_rx_err),
        .tx_ok(ev_tx_ok), .rx_ok(ev_rx_ok),
        .recover(recover_req),
        .tec(tec), .rec_raw(rec_raw), .flags(flags), .rx_pass(rx_pass)
    );

    canf_stat_irq u_stat (
        .clk(clk), .rst_n(rst_n), .flags(flags),
        .rx_ok(ev_rx_ok), .tx_ok(ev_tx_ok),
        .lec_vld(ev_lec_vld), .lec(ev_lec),
        .err_ie(err_ie), .stat_ie(stat_ie),
        .cpu_rd(cpu_rd_stat), .cpu_wr(cpu_wr_stat), .cpu_wdata(cpu_wdata),
        .low_bits(low_bits), .irq(irq)
    );

    // Receive read-back: saturate at the field maximum once the count is passive.
    always_comb rec_field = rx_pass ? {REC_W{1'b1}} : rec_raw[REC_W-1:0];

    // CPU word assembly.
    always_comb begin
        stat_word = {{STAT_PAD{1'b0}}, flags.boff, flags.warn, flags.pass, low_bits};
        cnt_word  = {{CNT_PAD{1'b0}}, rx_pass, rec_field, tec};
    end

    // R4
    rec_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rx_err && !flags.boff && rec_raw == (REC_W+1)'(PASS_LIM - 1)) |=> (cnt_word[TEC_W+REC_W] && flags.pass));
endmodule

// File: tb/sim_can_fault_irq.sv
module sim_can_fault_irq;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        ev_tx_err, ev_rx_err, ev_tx_ok, ev_rx_ok, ev_lec_vld;
    logic [2:0]  ev_lec;
    logic        recover_req, err_ie, stat_ie, cpu_rd_stat, cpu_wr_stat;
    logic [4:0]  cpu_wdata;
    logic [31:0] stat_word, cnt_word;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #4 clk = ~clk;  // 125 MHz

    can_fault_irq u0 (
        .clk(clk), .rst_n(rst_n),
        .ev_tx_err(ev_tx_err), .ev_rx_err(ev_rx_err),
        .ev_tx_ok(ev_tx_ok), .ev_rx_ok(ev_rx_ok),
        .ev_lec_vld(ev_lec_vld), .ev_lec(ev_lec),
        .recover_req(recover_req), .err_ie(err_ie), .stat_ie(stat_ie),
        .cpu_rd_stat(cpu_rd_stat), .cpu_wr_stat(cpu_wr_stat), .cpu_wdata(cpu_wdata),
        .stat_word(stat_word), .cnt_word(cnt_word), .irq(irq)
    );

    // Vector: [21:18] {tx_err,rx_err,tx_ok,rx_ok}, [17:10] tec, [9:3] rec field, [2:0] {boff,warn,pass}
    localparam logic [21:0] VEC [9] = '{
        {4'b1000, 8'd8,  7'd0, 3'b000},
        {4'b1000, 8'd16, 7'd0, 3'b000},
        {4'b0100, 8'd16, 7'd1, 3'b000},
        {4'b0010, 8'd15, 7'd1, 3'b000},
        {4'b0001, 8'd15, 7'd0, 3'b000},
        {4'b0001, 8'd15, 7'd0, 3'b000},
        {4'b1010, 8'd23, 7'd0, 3'b000},
        {4'b0101, 8'd23, 7'd1, 3'b000},
        {4'b0010, 8'd22, 7'd1, 3'b000}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic clear_inputs();
        {ev_tx_err, ev_rx_err, ev_tx_ok, ev_rx_ok, ev_lec_vld, recover_req} = '0;
        {cpu_rd_stat, cpu_wr_stat} = '0;
        ev_lec = '0;
        cpu_wdata = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        clear_inputs();
        idle(2);
        rst_n = 1'b1;
    endtask

    // Drive one cycle of strobes {tx_err,rx_err,tx_ok,rx_ok}; returns at the negedge after the update.
    task automatic pulse(input logic [3:0] e);
        {ev_tx_err, ev_rx_err, ev_tx_ok, ev_rx_ok} = e;
        @(negedge clk);
        {ev_tx_err, ev_rx_err, ev_tx_ok, ev_rx_ok} = '0;
    endtask

    task automatic repeat_pulse(input logic [3:0] e, input int n);
        for (int i = 0; i < n; i++) pulse(e);
    endtask

    task automatic cpu_read();
        cpu_rd_stat = 1'b1;
        @(negedge clk);
        cpu_rd_stat = 1'b0;
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        rst_n = 1'b0;
        err_ie = 1'b0;
        stat_ie = 1'b0;
        clear_inputs();
        do_reset();

        // R1 reset state
        chk(stat_word == 32'h0, "R1 stat", stat_word, 32'h0);
        chk(cnt_word == 32'h0,  "R1 cnt",  cnt_word, 32'h0);
        chk(irq == 1'b0,        "R1 irq",  {31'b0, irq}, 32'h0);

        // R2 vector table walk
        for (int i = 0; i < 9; i++) begin
            pulse(VEC[i][21:18]);
            chk(cnt_word[7:0] == VEC[i][17:10], "R2 tec", cnt_word, {24'b0, VEC[i][17:10]});
            chk(cnt_word[14:8] == VEC[i][9:3], "R2 rec", cnt_word, {25'b0, VEC[i][9:3]});
            chk(stat_word[7:5] == VEC[i][2:0], "R2 flags", stat_word, {24'b0, VEC[i][2:0], 5'b0});
        end

        // R3 warning at 96 on transmit counter, R5 bus-off, R7 error interrupt
        do_reset();
        err_ie = 1'b1;
        repeat_pulse(4'b1000, 11);
        chk(stat_word[6] == 1'b0, "R3 warn below", stat_word, 32'h0);
        pulse(4'b1000);
        chk(cnt_word[7:0] == 8'd96 && stat_word[6], "R3 warn at 96", {cnt_word[7:0], stat_word[23:0]}, 32'h60000040);
        chk(irq == 1'b0, "R7 irq not yet", {31'b0, irq}, 32'h0);
        idle(1);
        chk(irq == 1'b1, "R7 irq on warn", {31'b0, irq}, 32'h1);
        cpu_read();
        chk(irq == 1'b0, "R10 read clears", {31'b0, irq}, 32'h0);
        repeat_pulse(4'b1000, 4);
        chk(stat_word[7:5] == 3'b011, "R4 tx passive at 128", stat_word, 32'h60);
        idle(1);
        chk(irq == 1'b0, "R9 passive alone no irq", {31'b0, irq}, 32'h0);
        repeat_pulse(4'b1000, 15);
        chk(cnt_word[7:0] == 8'd248 && !stat_word[7], "R5 tec 248", cnt_word, 32'hF8);
        pulse(4'b1000);
        chk(cnt_word[7:0] == 8'd255 && stat_word[7], "R5 bus-off", {cnt_word[7:0], stat_word[23:0]}, 32'hFF0000E0);
        idle(1);
        chk(irq == 1'b1, "R7 irq on bus-off", {31'b0, irq}, 32'h1);
        pulse(4'b0011);
        pulse(4'b0100);
        chk(cnt_word[15:0] == 16'h00FF, "R5 frozen in bus-off", cnt_word, 32'hFF);
        recover_req = 1'b1;
        @(negedge clk);
        recover_req = 1'b0;
        chk(cnt_word == 32'h0 && stat_word[7:5] == 3'b000, "R5 recover", {cnt_word[15:0], 8'b0, stat_word[7:0]}, 32'h0);

        // R4 receive passive read-back, R9 passive change alone
        do_reset();
        err_ie = 1'b1;
        repeat_pulse(4'b0100, 96);
        idle(1);
        chk(irq == 1'b1, "R7 irq on rx warn", {31'b0, irq}, 32'h1);
        cpu_read();
        repeat_pulse(4'b0100, 31);
        chk(cnt_word[15:8] == 8'h7F && !stat_word[5], "R4 rec 127", cnt_word, 32'h7F00);
        pulse(4'b0100);
        chk(cnt_word[15:8] == 8'hFF && stat_word[5], "R4 rec 128 reads 127+rp", cnt_word, 32'hFF00);
        chk(cnt_word[31:16] == 16'h0 && stat_word[31:8] == 24'h0, "R6 upper zero", cnt_word, 32'hFF00);
        idle(2);
        chk(irq == 1'b0, "R9 rx passive no irq", {31'b0, irq}, 32'h0);

        // R8 status updates, R9 CPU write, R10 collision
        do_reset();
        stat_ie = 1'b1;
        ev_lec_vld = 1'b1;
        ev_lec = 3'b101;
        @(negedge clk);
        ev_lec_vld = 1'b0;
        chk(stat_word[2:0] == 3'b101, "R8 lec load", stat_word, 32'h5);
        chk(irq == 1'b1, "R8 irq on lec", {31'b0, irq}, 32'h1);
        cpu_read();
        pulse(4'b0001);
        chk(stat_word[4] && irq, "R8 rx_ok bit 4", stat_word, 32'h15);
        cpu_read();
        pulse(4'b0010);
        chk(stat_word[3] && irq, "R8 tx_ok bit 3", stat_word, 32'h1D);
        cpu_read();
        cpu_wr_stat = 1'b1;
        cpu_wdata = 5'b00000;
        @(negedge clk);
        cpu_wr_stat = 1'b0;
        chk(stat_word[4:0] == 5'b0, "R9 write clears low", stat_word, 32'h0);
        chk(irq == 1'b0, "R9 write no irq", {31'b0, irq}, 32'h0);
        cpu_wr_stat = 1'b1;
        cpu_wdata = 5'b10110;
        @(negedge clk);
        cpu_wr_stat = 1'b0;
        chk(stat_word[4:0] == 5'b10110 && !irq, "R9 write loads", stat_word, 32'h16);
        cpu_rd_stat = 1'b1;
        ev_rx_ok = 1'b1;
        @(negedge clk);
        cpu_rd_stat = 1'b0;
        ev_rx_ok = 1'b0;
        chk(irq == 1'b1, "R10 event beats read", {31'b0, irq}, 32'h1);

        report();
    end
endmodule